// File: doc/BRIEF.md
# Multi-mode transport frame octet packer

This block packs one frame's worth of decimated complex samples onto a set of parallel octet lanes for a JESD204B transport layer. Four input channels each deliver two bands. Each band carries a 16-bit I word and a 16-bit Q word, which makes 16 logical converters with one sample per frame. Once per frame the block registers all 32 octets together. It then sends them out over 8, 4, 2 or 1 lanes, one octet per lane on every octet clock. Each active lane flags the first octet of every frame.

The lane count is a static choice. A single octet counter counts through the frame, and its length F (4, 8, 16 or 32 octets) follows from the chosen lane count. The 32 octets always form one fixed stream. Each active lane takes its own contiguous slice of that stream. When no fresh samples are offered at a frame boundary, the last frame's samples are sent again and an underflow indicator is raised. Line coding, scrambling, lane alignment and the serialisers sit downstream of this block.

Top module: `frame_octet_packer`

## Requirements
- R1: While `rst_n` is low, every lane outputs 0x00 with `lane_valid`, `lane_sof` and `underflow` all low.
- R2: `mode_sel` encodes the lane count L and frame length F: 0 gives L=8 and F=4, 1 gives L=4 and F=8, 2 gives L=2 and F=16, 3 gives L=1 and F=32. While frames run, `lane_valid` is high on lanes 0..L-1 and only there.
- R3: Band index k = 2*channel + (band-1), with channels numbered 0..3. Band k takes `smp_i[16k+15:16k]` and `smp_q[16k+15:16k]`. Its four octets are I[15:8], I[7:0], Q[15:8] and Q[7:0]. The 32-octet stream lists bands k=0..7 in order. Octet n of lane l carries stream octet l*F+n.
- R4: Each active lane presents a new octet on every clock. A frame spans exactly F clocks. `lane_sof` is high on octet 0 of every frame, on all active lanes at once.
- R5: All 16 words are registered together at the clock edge that starts a frame. Changes to `smp_i` and `smp_q` at any other edge do not alter the frame in flight.
- R6: Lanes at index L and above output 0x00, with `lane_valid` and `lane_sof` low.
- R7: `mode_sel` is sampled only while the internal synchronised reset is still asserted. That window is the reset itself plus the first two rising edges after `rst_n` is released. Later changes have no effect until the next reset.
- R8: If `smp_valid` is low at a frame-start edge, the previous frame's samples are sent again (all zero if none were ever captured). `underflow` is then high for all F clocks of that frame. It returns low at the next frame that captures valid samples.
- R9: Reset release is synchronised. Octet 0 of the first frame appears after the third rising edge that follows the release of `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Lane-count select, encoded as in R2 |
| smp_valid | input | 1 | Samples on `smp_i`/`smp_q` are fresh |
| smp_i | input | 128 | I words of the 8 bands, band k at bits 16k+15..16k |
| smp_q | input | 128 | Q words of the 8 bands, band k at bits 16k+15..16k |
| lane_data | output | 64 | Octet of lane l at bits 8l+7..8l |
| lane_valid | output | 8 | Lane carries frame data |
| lane_sof | output | 8 | Lane is presenting octet 0 of a frame |
| underflow | output | 1 | Current frame repeats older samples |

## Verification
Two functions share the frame-start edge: the capture of all sixteen words, and the underflow decision to repeat the previous frame. The bench makes them meet by dropping `smp_valid` at random, in about a quarter of the clocks. Some of those drops land on frame boundaries and some land mid-frame. The input words also change on every clock, so mid-frame leakage would show up at once. A behavioural model decides each boundary from the valid level at that edge alone. The octets, the flags and `underflow` are then compared on every clock. This shows that a mid-frame drop leaves the frame untouched and that a boundary drop replays the old words for exactly one frame.

// File: rtl/fop_pkg.sv
package fop_pkg;

  // Lane-count selection; the encoding is the shift that turns the
  // widest configuration into the selected one.
  typedef enum logic [1:0] {
    LANES8 = 2'd0,
    LANES4 = 2'd1,
    LANES2 = 2'd2,
    LANES1 = 2'd3
  } lane_mode_e;

endpackage

// File: rtl/fop_rst_sync.sv
module fop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/fop_frame_ctrl.sv
module fop_frame_ctrl #(
  parameter int MAX_LANES = 8,
  parameter int TOTAL_OCT = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rst_sync_n,
  input  fop_pkg::lane_mode_e        mode_sel,
  output fop_pkg::lane_mode_e        mode_q,
  output logic [$clog2(TOTAL_OCT)-1:0] phase_q,
  output logic                       primed_q,
  output logic                       load
);

  localparam int PH_W  = $clog2(TOTAL_OCT);
  localparam int MIN_F = TOTAL_OCT / MAX_LANES;

  logic              mode_en;
  logic [PH_W:0]     frame_len;
  logic              last_oct;
  logic [PH_W-1:0]   phase_d;
  logic              primed_d;

  // Mode latch: enabled only while the synchronised reset is held.
  assign mode_en = !rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= fop_pkg::LANES8;
    end else if (mode_en) begin
      mode_q <= mode_sel;
    end
  end

  // Next-state logic for the octet counter.
  always_comb begin
    frame_len = (PH_W+1)'(MIN_F) << mode_q;
    last_oct  = ({1'b0, phase_q} == (frame_len - 1'b1));
    load      = !primed_q || last_oct;
    phase_d   = load ? '0 : phase_q + 1'b1;
    primed_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q  <= '0;
      primed_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      primed_q <= primed_d;
    end
  end

  AST_PHASE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ({1'b0, phase_q} < frame_len)); // R4
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (primed_q && last_oct) |=> (phase_q == '0)); // R4
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (primed_q && !last_oct) |=> (phase_q == $past(phase_q) + 1'b1)); // R4
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_sync_n |=> $stable(mode_q)); // R7

endmodule

// File: rtl/fop_sample_store.sv
module fop_sample_store #(
  parameter int N_BANDS = 8,
  parameter int WORD_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      in_valid,
  input  logic [N_BANDS*WORD_W-1:0] in_i,
  input  logic [N_BANDS*WORD_W-1:0] in_q,
  output logic [N_BANDS*WORD_W-1:0] buf_i_q,
  output logic [N_BANDS*WORD_W-1:0] buf_q_q,
  output logic                      underflow_q
);

  localparam int BUS_W = N_BANDS * WORD_W;

  logic [BUS_W-1:0] buf_i_d;
  logic [BUS_W-1:0] buf_q_d;
  logic             underflow_d;
  logic             take;

  always_comb begin
    take        = load && in_valid;
    buf_i_d     = take ? in_i : buf_i_q;
    buf_q_d     = take ? in_q : buf_q_q;
    underflow_d = load ? !in_valid : underflow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_i_q     <= '0;
      buf_q_q     <= '0;
      underflow_q <= 1'b0;
    end else begin
      buf_i_q     <= buf_i_d;
      buf_q_q     <= buf_q_d;
      underflow_q <= underflow_d;
    end
  end

  AST_CAPTURE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (load && in_valid) |=> (buf_i_q == $past(in_i) && buf_q_q == $past(in_q))); // R5
  AST_NO_MIDFRAME_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(buf_i_q) && $stable(buf_q_q) && $stable(underflow_q))); // R5
  AST_REPEAT_ON_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !in_valid) |=> ($stable(buf_i_q) && $stable(buf_q_q) && underflow_q)); // R8

endmodule

// File: rtl/fop_lane_mux.sv
module fop_lane_mux #(
  parameter int N_BANDS   = 8,
  parameter int WORD_W    = 16,
  parameter int MAX_LANES = 8,
  parameter int TOTAL_OCT = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  fop_pkg::lane_mode_e           mode_q,
  input  logic [$clog2(TOTAL_OCT)-1:0]  phase_q,
  input  logic                          primed_q,
  input  logic [N_BANDS*WORD_W-1:0]     buf_i,
  input  logic [N_BANDS*WORD_W-1:0]     buf_q,
  output logic [MAX_LANES*8-1:0]        lane_data,
  output logic [MAX_LANES-1:0]          lane_valid,
  output logic [MAX_LANES-1:0]          lane_sof
);

  localparam int PH_W   = $clog2(TOTAL_OCT);
  localparam int OPW    = WORD_W / 8;
  localparam int OPB    = 2 * OPW;
  localparam int MIN_F  = TOTAL_OCT / MAX_LANES;
  localparam int MIN_SH = $clog2(MIN_F);
  localparam int LANE_W = $clog2(MAX_LANES);

  logic [7:0]      stream [TOTAL_OCT];
  logic [LANE_W:0] n_active;

  assign n_active = (LANE_W+1)'(MAX_LANES) >> mode_q;

  // Flatten the captured words into the fixed octet stream.
  for (genvar b = 0; b < N_BANDS; b++) begin : g_band
    for (genvar o = 0; o < OPB; o++) begin : g_oct
      if (o < OPW) begin : g_i
        assign stream[b*OPB + o] = buf_i[b*WORD_W + (OPW-1-o)*8 +: 8];
      end else begin : g_q
        assign stream[b*OPB + o] = buf_q[b*WORD_W + (OPB-1-o)*8 +: 8];
      end
    end
  end

  // Each lane reads its own contiguous slice of the stream.
  for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
    logic            act;
    logic [PH_W-1:0] sel;
    logic [7:0]      oct;

    always_comb begin
      act = primed_q && ((LANE_W+1)'(l) < n_active);
      sel = PH_W'(32'(l) << (MIN_SH + 32'(mode_q))) + phase_q;
      oct = act ? stream[sel] : 8'h00;
    end

    assign lane_data[l*8 +: 8] = oct;
    assign lane_valid[l]       = act;
    assign lane_sof[l]         = act && (phase_q == '0);

    AST_IDLE_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_valid[l] |-> (lane_data[l*8 +: 8] == 8'h00 && !lane_sof[l])); // R6
  end

endmodule

// File: rtl/frame_octet_packer.sv
module frame_octet_packer #(
  parameter int N_CH      = 4,
  parameter int BANDS_CH  = 2,
  parameter int WORD_W    = 16,
  parameter int MAX_LANES = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [1:0]                         mode_sel,
  input  logic                               smp_valid,
  input  logic [N_CH*BANDS_CH*WORD_W-1:0]    smp_i,
  input  logic [N_CH*BANDS_CH*WORD_W-1:0]    smp_q,
  output logic [MAX_LANES*8-1:0]             lane_data,
  output logic [MAX_LANES-1:0]               lane_valid,
  output logic [MAX_LANES-1:0]               lane_sof,
  output logic                               underflow
);

  localparam int N_BANDS   = N_CH * BANDS_CH;
  localparam int TOTAL_OCT = N_BANDS * 2 * (WORD_W / 8);
  localparam int PH_W      = $clog2(TOTAL_OCT);
  localparam int BUS_W     = N_BANDS * WORD_W;

  logic                 rst_sync_n;
  fop_pkg::lane_mode_e  mode_in;
  fop_pkg::lane_mode_e  mode_q;
  logic [PH_W-1:0]      phase_q;
  logic                 primed_q;
  logic                 load;
  logic [BUS_W-1:0]     buf_i;
  logic [BUS_W-1:0]     buf_q;

  assign mode_in = fop_pkg::lane_mode_e'(mode_sel);

  fop_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fop_frame_ctrl #(
    .MAX_LANES (MAX_LANES),
    .TOTAL_OCT (TOTAL_OCT)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n),
    .mode_sel   (mode_in),
    .mode_q     (mode_q),
    .phase_q    (phase_q),
    .primed_q   (primed_q),
    .load       (load)
  );

  fop_sample_store #(
    .N_BANDS (N_BANDS),
    .WORD_W  (WORD_W)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .load        (load),
    .in_valid    (smp_valid),
    .in_i        (smp_i),
    .in_q        (smp_q),
    .buf_i_q     (buf_i),
    .buf_q_q     (buf_q),
    .underflow_q (underflow)
  );

  fop_lane_mux #(
    .N_BANDS   (N_BANDS),
    .WORD_W    (WORD_W),
    .MAX_LANES (MAX_LANES),
    .TOTAL_OCT (TOTAL_OCT)
  ) u_mux (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mode_q     (mode_q),
    .phase_q    (phase_q),
    .primed_q   (primed_q),
    .buf_i      (buf_i),
    .buf_q      (buf_q),
    .lane_data  (lane_data),
    .lane_valid (lane_valid),
    .lane_sof   (lane_sof)
  );

  AST_SOF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|lane_sof) |-> (lane_sof == lane_valid)); // R4
  AST_VALID_PREFIX: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((lane_valid & (lane_valid + 1'b1)) == '0)); // R2
  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> (lane_valid == '0 && lane_sof == '0 && !underflow)); // R1

endmodule

// File: tb/sim_frame_octet_packer.sv
module sim_frame_octet_packer;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode_sel;
  logic         smp_valid;
  logic [127:0] smp_i;
  logic [127:0] smp_q;
  logic [63:0]  lane_data;
  logic [7:0]   lane_valid;
  logic [7:0]   lane_sof;
  logic         underflow;

  int checks   = 0;
  int failures = 0;

  // Reference model state
  int           sc;
  int           m_mode;
  bit           m_primed;
  int           m_ph;
  logic [127:0] m_bi;
  logic [127:0] m_bq;
  bit           m_und;

  always #5 clk = ~clk;

  frame_octet_packer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .smp_valid  (smp_valid),
    .smp_i      (smp_i),
    .smp_q      (smp_q),
    .lane_data  (lane_data),
    .lane_valid (lane_valid),
    .lane_sof   (lane_sof),
    .underflow  (underflow)
  );

  function automatic int flen(int m);
    return 4 << m;
  endfunction

  function automatic int nlanes(int m);
    return 8 >> m;
  endfunction

  function automatic logic [7:0] exp_byte(int l);
    int s, b, o;
    logic [15:0] w;
    if (!m_primed || l >= nlanes(m_mode)) return 8'h00;
    s = l * flen(m_mode) + m_ph;
    b = s / 4;
    o = s % 4;
    w = (o < 2) ? m_bi[b*16 +: 16] : m_bq[b*16 +: 16];
    return (o % 2 == 0) ? w[15:8] : w[7:0];
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      sc = 0; m_mode = 0; m_primed = 0; m_ph = 0;
      m_bi = '0; m_bq = '0; m_und = 0;
    end else begin
      if (sc < 2) begin
        m_mode = int'(mode_sel);
      end else if (!m_primed || m_ph == flen(m_mode) - 1) begin
        if (smp_valid) begin
          m_bi = smp_i; m_bq = smp_q; m_und = 0;
        end else begin
          m_und = 1;
        end
        m_ph = 0;
        m_primed = 1;
      end else begin
        m_ph++;
      end
      if (sc < 2) sc++;
    end
  endtask

  task automatic compare();
    for (int l = 0; l < 8; l++) begin
      logic [7:0] eb;
      bit         ev;
      eb = exp_byte(l);
      ev = m_primed && (l < nlanes(m_mode));
      chk(lane_data[l*8 +: 8] == eb, ev ? "R3 R5 lane octet" : "R6 idle lane octet",
          lane_data[l*8 +: 8], eb);
      chk(lane_valid[l] == ev, "R2 lane valid", lane_valid[l], ev);
      chk(lane_sof[l] == (ev && m_ph == 0), "R4 start flag", lane_sof[l], ev && m_ph == 0);
    end
    chk(underflow == (m_primed && m_und), "R8 underflow", underflow, m_primed && m_und);
  endtask

  task automatic tick();
    @(posedge clk);
    #1 model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic drive_random();
    smp_i     = {$urandom, $urandom, $urandom, $urandom};
    smp_q     = {$urandom, $urandom, $urandom, $urandom};
    smp_valid = ($urandom % 4) != 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'd0; smp_valid = 1'b0; smp_i = '0; smp_q = '0;
    sc = 0; m_mode = 0; m_primed = 0; m_ph = 0; m_bi = '0; m_bq = '0; m_und = 0;
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      rst_n = 1'b0; mode_sel = 2'(m); smp_valid = 1'b0;
      smp_i = {$urandom, $urandom, $urandom, $urandom};
      repeat (3) tick();
      // R1: quiet outputs while reset is held
      chk(lane_valid == 8'h00 && lane_sof == 8'h00 && lane_data == '0 && !underflow,
          "R1 reset state", {lane_valid, lane_sof, 7'd0, underflow}, 0);
      rst_n = 1'b1;
      tick();
      tick();
      // R9: still idle after the second edge following release
      chk(lane_valid == 8'h00, "R9 idle after second edge", lane_valid, 0);
      tick();
      // R9: frame starts after the third edge; R8: no samples yet, zeros repeated
      chk(lane_sof[0] == 1'b1, "R9 first frame start", lane_sof[0], 1);
      chk(underflow == 1'b1 && lane_data[7:0] == 8'h00, "R8 empty repeat",
          {underflow, lane_data[7:0]}, 9'h100);
      for (int c = 0; c < 12 * flen(m); c++) begin
        drive_random();
        if (c == 5 * flen(m)) mode_sel = 2'((m + 1) % 4);
        tick();
      end
      // R7: mode change after release had no effect
      chk(lane_valid == 8'((1 << nlanes(m)) - 1), "R7 mode held",
          lane_valid, (1 << nlanes(m)) - 1);
      // R8: starve a whole frame and confirm the flag
      smp_valid = 1'b0;
      for (int c = 0; c < 2 * flen(m); c++) tick();
      chk(underflow == 1'b1, "R8 sustained underflow", underflow, 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule